// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects up to sixteen interrupt sources into a pending register. It filters them through a mask and a global enable, and offers the most urgent eligible one to an instruction sequencer as a vector index with a valid flag. Priority is fixed by bit position: source 0 is the most urgent and source 15 the least. Source 0 is a debug-halt request that can never be masked. Source 1 is a sleep-wake request that only the global enable can block. Source 2 is a single-step request, source 3 is raised from stack-status alarms, and sources 4 to 15 are free for general use.

The sequencer accepts an offered interrupt with a one-cycle acknowledge. On that edge the controller clears the pending bit and records the index as in service. A return pulse retires the most recently entered service level. An optional nesting mode lets a strictly more urgent request interrupt one that is already in service. Software can set and clear pending bits directly, and can write the mask and a small control word.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending bits, the mask, the control word and the in-service record are all zero, and `reqValid` is low.
- R2: Among pending sources that are eligible, `vecIdx` names the one with the lowest index.
- R3: Source 0 is offered whenever it is pending, whatever the mask and the global enable hold.
- R4: Source 1 is eligible exactly when the global enable (control bit 5) is set; its mask bit has no effect.
- R5: Sources 2 to 15 are eligible only when their mask bit is 1 and the global enable (control bit 5) is 1.
- R6: Control bits 4 (nesting), 5 (global enable), 7, 10 (stack alarm enable) and 11 are writable. Every other control bit always reads 0 on `ctlOut`.
- R7: A `stackAlarm` pulse sets pending bit 3 only while control bit 10 is set. Otherwise it has no effect.
- R8: An `ack` while `reqValid` is high clears the pending bit of `vecIdx` and marks that index as in service on the same edge. An `ack` while `reqValid` is low changes nothing.
- R9: When a set (hardware request, software set or stack alarm) and a clear (software clear or acknowledge) hit the same pending bit in one cycle, the bit ends up set.
- R10: With nesting off (control bit 4 = 0), `reqValid` stays low while any level is in service.
- R11: With nesting on, a pending request is offered during service only if its index is strictly lower than the most urgent index in service.
- R12: An `rti` pulse retires the most urgent index in service and leaves any others in service.
- R13: A request input that is high for one cycle leaves its pending bit set after the input falls, until the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqIn | input | 16 | Hardware request lines, sampled at each edge |
| swSet | input | 16 | Software set of pending bits |
| swClr | input | 16 | Software clear of pending bits |
| maskWe | input | 1 | Mask write strobe |
| maskData | input | 16 | Mask value, 1 enables a source |
| ctlWe | input | 1 | Control word write strobe |
| ctlData | input | 16 | Control word value |
| stackAlarm | input | 1 | Stack status alarm pulse |
| ack | input | 1 | Sequencer accepts the offered interrupt |
| rti | input | 1 | Sequencer returns from the current service level |
| reqValid | output | 1 | An interrupt is being offered |
| vecIdx | output | 4 | Index of the offered interrupt |
| pendOut | output | 16 | Pending register contents |
| ctlOut | output | 16 | Control word contents |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that the sequencer sends `rti` only to close a level it acknowledged earlier, and sends `ack` only for the index currently offered. The stimulus changes inputs only on the falling edge and holds each pulse for one cycle. It issues `ack` in an idle cycle only in the single case that checks an acknowledge is ignored. The stimulus never raises `ack` and `rti` together, so that each service level opens and closes in a clear order.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NUM_SRC  = 16;
  localparam int unsigned IDX_W    = $clog2(NUM_SRC);
  localparam int unsigned CTL_W    = 16;
  localparam int unsigned CTL_NEST = 4;
  localparam int unsigned CTL_GIE  = 5;
  localparam int unsigned CTL_STK  = 10;
  localparam logic [CTL_W-1:0] CTL_KEEP = 16'h0CB0;
  localparam int unsigned SRC_HALT  = 0;
  localparam int unsigned SRC_WAKE  = 1;
  localparam int unsigned SRC_STACK = 3;

  typedef struct packed {
    logic             takeAck;
    logic [IDX_W-1:0] takeIdx;
  } svcStrobe_t;
endpackage

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irqIn,
  input  logic [N-1:0]     swSet,
  input  logic [N-1:0]     swClr,
  input  logic             maskWe,
  input  logic [N-1:0]     maskData,
  input  logic             ctlWe,
  input  logic [CTL_W-1:0] ctlData,
  input  logic             stackAlarm,
  input  svcStrobe_t       strobe,
  output logic [N-1:0]     pendQ,
  output logic [N-1:0]     maskQ,
  output logic [CTL_W-1:0] ctlQ
);
  logic [N-1:0] setBits;
  logic [N-1:0] clrBits;
  logic [N-1:0] ackOneHot;

  always_comb begin
    ackOneHot = '0;
    if (strobe.takeAck) ackOneHot[strobe.takeIdx] = 1'b1;
    setBits = irqIn | swSet;
    if (stackAlarm && ctlQ[CTL_STK]) setBits[SRC_STACK] = 1'b1;
    clrBits = swClr | ackOneHot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ <= '0;
      maskQ <= '0;
      ctlQ  <= '0;
    end else begin
      pendQ <= (pendQ & ~clrBits) | setBits;
      if (maskWe) maskQ <= maskData;
      if (ctlWe)  ctlQ  <= ctlData & CTL_KEEP;
    end
  end

  // R9: any set request lands in the pending register regardless of clears
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|setBits) |=> ((pendQ & $past(setBits)) == $past(setBits)));

  // R8: an accepted interrupt leaves its pending bit clear unless re-set
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.takeAck && !setBits[strobe.takeIdx]) |=> !pendQ[$past(strobe.takeIdx)]);
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pendQ,
  input  logic [N-1:0]  maskQ,
  input  logic          gieEn,
  input  logic          nestEn,
  input  logic          ack,
  input  logic          rti,
  output logic          reqValid,
  output logic [IW-1:0] vecIdx,
  output svcStrobe_t    strobe
);
  logic [N-1:0]  eligible;
  logic [N-1:0]  eligPend;
  logic [N-1:0]  activeQ;
  logic [N-1:0]  activeNext;
  logic          candAny;
  logic [IW-1:0] candIdx;
  logic          actAny;
  logic [IW-1:0] actIdx;
  logic          takeNow;
  logic          unusedMaskBits;

  assign unusedMaskBits = ^maskQ[SRC_WAKE:SRC_HALT];

  function automatic logic [IW:0] firstSet(input logic [N-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IW'(i)};
    end
    return r;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_elig
    if (g == SRC_HALT) begin : g_halt
      assign eligible[g] = 1'b1;
    end else if (g == SRC_WAKE) begin : g_wake
      assign eligible[g] = gieEn;
    end else begin : g_user
      assign eligible[g] = maskQ[g] & gieEn;
    end
  end

  assign eligPend = pendQ & eligible;
  assign {candAny, candIdx} = firstSet(eligPend);
  assign {actAny, actIdx}   = firstSet(activeQ);

  always_comb begin
    reqValid = candAny && (!actAny || (nestEn && (candIdx < actIdx)));
    vecIdx   = candIdx;
    takeNow  = ack && reqValid;
    strobe.takeAck = takeNow;
    strobe.takeIdx = candIdx;
    activeNext = activeQ;
    if (rti && actAny) activeNext[actIdx] = 1'b0;
    if (takeNow) activeNext[candIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) activeQ <= '0;
    else        activeQ <= activeNext;
  end

  // R2: the offered index is really pending
  a_r2_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> pendQ[vecIdx]);

  // R5: general sources need their mask bit and the global enable
  a_r5_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && (vecIdx > IW'(SRC_WAKE))) |-> (maskQ[vecIdx] && gieEn));

  // R4: the wake source needs only the global enable
  a_r4_wake_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && (vecIdx == IW'(SRC_WAKE))) |-> gieEn);

  // R10: without nesting nothing is offered during service
  a_r10_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
    ((|activeQ) && !nestEn) |-> !reqValid);

  // R12: a return retires exactly one level
  a_r12_rti_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && (|activeQ) && !takeNow) |=>
      ($countones(activeQ) == $countones($past(activeQ)) - 1));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irqIn,
  input  logic [N-1:0]     swSet,
  input  logic [N-1:0]     swClr,
  input  logic             maskWe,
  input  logic [N-1:0]     maskData,
  input  logic             ctlWe,
  input  logic [CTL_W-1:0] ctlData,
  input  logic             stackAlarm,
  input  logic             ack,
  input  logic             rti,
  output logic             reqValid,
  output logic [IW-1:0]    vecIdx,
  output logic [N-1:0]     pendOut,
  output logic [CTL_W-1:0] ctlOut
);
  svcStrobe_t   strobe;
  logic [N-1:0] maskQ;

  irq_prio_dp #(.N(N)) u_dp (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .swSet(swSet), .swClr(swClr),
    .maskWe(maskWe), .maskData(maskData), .ctlWe(ctlWe), .ctlData(ctlData),
    .stackAlarm(stackAlarm), .strobe(strobe), .pendQ(pendOut),
    .maskQ(maskQ), .ctlQ(ctlOut)
  );

  irq_prio_ctl #(.N(N)) u_ctl (
    .clk(clk), .rst_n(rst_n), .pendQ(pendOut), .maskQ(maskQ),
    .gieEn(ctlOut[CTL_GIE]), .nestEn(ctlOut[CTL_NEST]), .ack(ack), .rti(rti),
    .reqValid(reqValid), .vecIdx(vecIdx), .strobe(strobe)
  );
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irqIn = '0, swSet = '0, swClr = '0, maskData = '0, ctlData = '0;
  logic        maskWe = 1'b0, ctlWe = 1'b0, stackAlarm = 1'b0, ack = 1'b0, rti = 1'b0;
  logic        reqValid;
  logic [3:0]  vecIdx;
  logic [15:0] pendOut, ctlOut;

  typedef struct {
    logic        v;
    logic [3:0]  idx;
    logic [15:0] pend;
    logic [15:0] ctl;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] expCtl = '0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .swSet(swSet), .swClr(swClr),
    .maskWe(maskWe), .maskData(maskData), .ctlWe(ctlWe), .ctlData(ctlData),
    .stackAlarm(stackAlarm), .ack(ack), .rti(rti), .reqValid(reqValid),
    .vecIdx(vecIdx), .pendOut(pendOut), .ctlOut(ctlOut)
  );

  // monitor: compare one queued expectation after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (reqValid !== e.v || (e.v && vecIdx !== e.idx) ||
            pendOut !== e.pend || ctlOut !== e.ctl) begin
          errors++;
          $display("FAIL %s: got valid=%0b idx=%0d pend=%h ctl=%h, want valid=%0b idx=%0d pend=%h ctl=%h",
                   e.tag, reqValid, vecIdx, pendOut, ctlOut, e.v, e.idx, e.pend, e.ctl);
        end
      end
    end
  end

  task automatic tick(input logic v, input logic [3:0] idx, input logic [15:0] pend,
                      input string tag);
    exp_t e;
    e.v = v; e.idx = idx; e.pend = pend; e.ctl = expCtl; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    irqIn = '0; swSet = '0; swClr = '0; maskWe = 0; ctlWe = 0;
    stackAlarm = 0; ack = 0; rti = 0;
  endtask

  task automatic wrCtl(input logic [15:0] d);
    ctlWe = 1; ctlData = d; expCtl = d & 16'h0CB0;
  endtask

  task automatic wrMask(input logic [15:0] d);
    maskWe = 1; maskData = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(0, 0, 16'h0000, "R1 reset state");
    wrCtl(16'hFFFF);                tick(0, 0, 16'h0000, "R6 reserved bits read zero");
    wrCtl(16'h0000);                tick(0, 0, 16'h0000, "R6 control cleared");
    irqIn = 16'h0020;               tick(0, 0, 16'h0020, "R5 masked user source");
                                    tick(0, 0, 16'h0020, "R13 pending held after input drops");
    wrMask(16'hFFFF);               tick(0, 0, 16'h0020, "R5 mask alone not enough without enable");
    irqIn = 16'h0002;               tick(0, 0, 16'h0022, "R4 wake blocked by enable off");
    irqIn = 16'h0001;               tick(1, 0, 16'h0023, "R3 halt source unmaskable");
    ack = 1;                        tick(0, 0, 16'h0022, "R8 ack clears bit 0");
    rti = 1;                        tick(0, 0, 16'h0022, "R12 return with enable off");
    wrCtl(16'h0020);                tick(1, 1, 16'h0022, "R2 wake beats user source");
    wrMask(16'hFFFD);               tick(1, 1, 16'h0022, "R4 wake mask bit no effect");
    ack = 1;                        tick(0, 0, 16'h0020, "R8 ack clears bit 1");
    irqIn = 16'h0004;               tick(0, 0, 16'h0024, "R10 no offer while in service");
    wrCtl(16'h0030);                tick(0, 0, 16'h0024, "R11 lower priority cannot preempt");
    rti = 1;                        tick(1, 2, 16'h0024, "R12 return reopens offers");
    ack = 1;                        tick(0, 0, 16'h0020, "R11 bit 5 waits behind level 2");
    irqIn = 16'h0001;               tick(1, 0, 16'h0021, "R11 higher priority preempts");
    ack = 1;                        tick(0, 0, 16'h0020, "R8 nested ack");
    rti = 1;                        tick(0, 0, 16'h0020, "R12 retires most urgent level only");
    rti = 1;                        tick(1, 5, 16'h0020, "R12 last level retired");
    wrMask(16'hFFDF);               tick(0, 0, 16'h0020, "R5 mask bit off blocks");
    ack = 1;                        tick(0, 0, 16'h0020, "R8 ack without offer ignored");
    stackAlarm = 1;                 tick(0, 0, 16'h0020, "R7 alarm ignored when disabled");
    wrCtl(16'h0430);                tick(0, 0, 16'h0020, "R6 stack enable written");
    stackAlarm = 1;                 tick(1, 3, 16'h0028, "R7 alarm sets bit 3");
    swSet = 16'h0008; swClr = 16'h0008;
                                    tick(1, 3, 16'h0028, "R9 set beats clear");
    swClr = 16'h0028;               tick(0, 0, 16'h0000, "R9 plain clear");
    swSet = 16'h0200;               tick(1, 9, 16'h0200, "R2 single user source");
    ack = 1; swSet = 16'h0200;      tick(0, 0, 16'h0200, "R9 set beats ack clear");
    rti = 1;                        tick(1, 9, 16'h0200, "R11 equal level only after return");
    swSet = 16'hF000;               tick(1, 9, 16'hF200, "R2 lowest index wins");
    swClr = 16'h0200;               tick(1, 12, 16'hF000, "R2 next in line");
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule